// File: doc/BRIEF.md
# Interrupt Processor-Routing Byte Bank

This block keeps, for every interrupt line of a distributor, one byte that says which processors may take that interrupt. Software reaches the bytes through a byte-wide register port. Each access names the processor that issued it. The stored masks are driven out in parallel to the forwarding logic. Each mask holds one bit per processor, and the mask for interrupt `i` sits at bits `[i*NUM_CPU +: NUM_CPU]` of `targetMask`.

The bank decodes byte offsets 0x800 up to 0xBFF of a 12-bit distributor offset. The interrupt number of a byte is its offset minus 0x800, plus `BASE_IRQ`. Interrupts below 32 are private to each processor, and writes to them are forced:
- Writes to interrupts 0 to 28 store zero.
- Writes to interrupts 29 to 31 store the all-processors mask.
- Reads of interrupts 29 to 31 report the requester's own bit instead of a stored value.

A build with one processor hides the bank from software: reads return zero and writes are dropped, while every interrupt still routes to processor 0. Setting `LEGACY_REV` keeps the full register behaviour even with one processor.

Top module: `irq_target_bank`

## Requirements
- R1: A request whose offset lies outside 0x800..0xBFF returns data 0 with no error and changes no target mask.
- R2: Every request (read or write) is answered by `rspValid` high for exactly one cycle, in the cycle after the request. A write updates `targetMask` on the clock edge that samples it, and its response data is 0.
- R3: A valid read of a shared interrupt (number 32 or above, below `NUM_IRQ`) returns that interrupt's stored mask, zero-extended to 8 bits.
- R4: A write to a shared interrupt stores the written byte ANDed with the all-processors mask. That mask is the low `NUM_CPU` bits set.
- R5: A write to an interrupt numbered 0 to 28 stores 0, whatever data was written.
- R6: A write to interrupt 29, 30 or 31 stores the all-processors mask, whatever data was written.
- R7: A read of interrupt 29, 30 or 31 returns `1 << reqCpu`, whatever is stored.
- R8: A decoded interrupt number at or above `NUM_IRQ` gives a response with data 0 and `rspErr` high for that single response cycle. A write of this kind changes no mask.
- R9: With `NUM_CPU` = 1 and `LEGACY_REV` = 0, every in-window read returns 0 without error, every write is dropped, and every bit of `targetMask` is 1 at all times.
- R10: With `NUM_CPU` = 1 and `LEGACY_REV` = 1, all masks reset to 1 and the write, read and error rules R3 to R8 apply.
- R11: With `NUM_CPU` > 1, all masks reset to 0. During reset `rspValid`, `rspErr` and `rspRdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Distributor byte offset |
| reqWdata | input | 8 | Write byte |
| reqCpu | input | CPUW | Index of the requesting processor |
| rspValid | output | 1 | Response cycle, one after the request |
| rspRdata | output | 8 | Read data (0 for writes and errors) |
| rspErr | output | 1 | Invalid-register access |
| targetMask | output | NUM_IRQ*NUM_CPU | Per-interrupt routing masks |

## Verification
The assertions assume `reqCpu` is below `NUM_CPU` whenever `reqValid` is high. They also assume `reqValid` is held low through reset. The bench drives every request on the falling edge, after reset has been released, using only processor indices 0 to 3 for the four-processor build. The one-processor instances have `reqCpu` tied to zero. Under these conditions the response and mask relations the assertions rely on are always well defined.

// File: rtl/irq_target_pkg.sv
package irq_target_pkg;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STORED = 2'd1,
    RD_SELF   = 2'd2
  } rdSel_e;

  // Strobes from decode to storage
  typedef struct packed {
    logic       wrEn;
    logic       err;
    rdSel_e     rdSel;
    logic [9:0] idx;
    logic [7:0] wrVal;
  } bankStrb_t;

endpackage

// File: rtl/irq_target_ctrl.sv
module irq_target_ctrl
  import irq_target_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int NUM_IRQ    = 64,
  parameter bit LEGACY_REV = 1'b0,
  parameter int BASE_IRQ   = 0
) (
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [11:0] reqAddr,
  input  logic [7:0]  reqWdata,
  output bankStrb_t   strb
);

  localparam bit        HIDDEN   = (NUM_CPU == 1) && !LEGACY_REV;
  localparam logic [7:0] ALL_MASK = 8'((1 << NUM_CPU) - 1);

  logic        inWin;
  logic [10:0] irqNum;

  assign inWin  = (reqAddr[11:10] == 2'b10);
  assign irqNum = {1'b0, reqAddr[9:0]} + 11'(BASE_IRQ);

  always_comb begin
    strb = '0;
    if (reqValid && inWin && !HIDDEN) begin
      if (int'(irqNum) >= NUM_IRQ) begin
        strb.err = 1'b1;
      end else begin
        strb.idx = irqNum[9:0];
        if (reqWrite) begin
          strb.wrEn = 1'b1;
          if (irqNum < 11'd29)      strb.wrVal = 8'h00;
          else if (irqNum < 11'd32) strb.wrVal = ALL_MASK;
          else                      strb.wrVal = reqWdata & ALL_MASK;
        end else begin
          strb.rdSel = (irqNum >= 11'd29 && irqNum < 11'd32) ? RD_SELF : RD_STORED;
        end
      end
    end
  end

endmodule

// File: rtl/irq_target_dp.sv
module irq_target_dp
  import irq_target_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int NUM_IRQ    = 64,
  parameter bit LEGACY_REV = 1'b0,
  parameter int CPUW       = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [CPUW-1:0]            reqCpu,
  input  bankStrb_t                  strb,
  output logic                       rspValid,
  output logic [7:0]                 rspRdata,
  output logic                       rspErr,
  output logic [NUM_IRQ*NUM_CPU-1:0] targetMask
);

  localparam bit HIDDEN = (NUM_CPU == 1) && !LEGACY_REV;
  localparam int IDXW   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [NUM_CPU-1:0] RST_TGT = NUM_CPU'((NUM_CPU == 1) ? 1 : 0);

  logic [NUM_CPU-1:0] tgt [NUM_IRQ];
  logic [NUM_CPU-1:0] rdStored;
  logic [7:0]         selfMask;
  logic               unusedBits;

  assign unusedBits = ^{strb.wrVal, strb.idx};

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    if (HIDDEN) begin : g_fixed
      assign tgt[i] = '1;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN)
          tgt[i] <= RST_TGT;
        else if (strb.wrEn && strb.idx == 10'(i))
          tgt[i] <= strb.wrVal[NUM_CPU-1:0];
      end
    end
    assign targetMask[i*NUM_CPU +: NUM_CPU] = tgt[i];
  end

  assign rdStored = tgt[strb.idx[IDXW-1:0]];
  assign selfMask = 8'(1) << reqCpu;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= 8'h00;
    end else begin
      rspValid <= reqValid;
      rspErr   <= strb.err;
      case (strb.rdSel)
        RD_STORED: rspRdata <= 8'(rdStored);
        RD_SELF:   rspRdata <= selfMask;
        default:   rspRdata <= 8'h00;
      endcase
    end
  end

  // R8: an error flag only appears on a response cycle
  a_r8_err_in_rsp : assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

  // R8: an invalid access left every mask as it was
  a_r8_err_no_change : assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> $stable(targetMask));

  if (HIDDEN) begin : g_hidden_chk
    // R9: hidden bank reads zero and masks never move
    a_r9_raz : assert property (@(posedge clk) disable iff (!rstN)
      rspValid |-> (rspRdata == 8'h00 && !rspErr));
    a_r9_wi : assert property (@(posedge clk) disable iff (!rstN)
      rspValid |-> $stable(targetMask));
  end

  if (NUM_CPU > 1) begin : g_low_chk
    for (genvar j = 0; j < 29 && j < NUM_IRQ; j++) begin : g_low
      // R5: low private lines never route anywhere
      a_r5_low_zero : assert property (@(posedge clk) disable iff (!rstN)
        tgt[j] == '0);
    end
  end

endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank
  import irq_target_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int NUM_IRQ    = 64,
  parameter bit LEGACY_REV = 1'b0,
  parameter int BASE_IRQ   = 0,
  localparam int CPUW      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [11:0]                reqAddr,
  input  logic [7:0]                 reqWdata,
  input  logic [CPUW-1:0]            reqCpu,
  output logic                       rspValid,
  output logic [7:0]                 rspRdata,
  output logic                       rspErr,
  output logic [NUM_IRQ*NUM_CPU-1:0] targetMask
);

  bankStrb_t strb;

  irq_target_ctrl #(
    .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ),
    .LEGACY_REV(LEGACY_REV), .BASE_IRQ(BASE_IRQ)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .strb(strb)
  );

  irq_target_dp #(
    .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ),
    .LEGACY_REV(LEGACY_REV), .CPUW(CPUW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCpu(reqCpu),
    .strb(strb), .rspValid(rspValid), .rspRdata(rspRdata),
    .rspErr(rspErr), .targetMask(targetMask)
  );

endmodule

// File: tb/irq_target_bank_bench.sv
`timescale 1ns/1ps
module irq_target_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [1:0]  reqCpu = '0;

  logic        vM, eM, vU, eU, vL, eL;
  logic [7:0]  dM, dU, dL;
  logic [255:0] tgtM;
  logic [63:0]  tgtU, tgtL;

  logic [3:0] expM [64];
  logic       expL [64];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_target_bank #(.NUM_CPU(4), .NUM_IRQ(64), .LEGACY_REV(1'b0)) u_irq_target_bank (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqCpu(reqCpu),
    .rspValid(vM), .rspRdata(dM), .rspErr(eM), .targetMask(tgtM));

  irq_target_bank #(.NUM_CPU(1), .NUM_IRQ(64), .LEGACY_REV(1'b0)) u_uni (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqCpu(1'b0),
    .rspValid(vU), .rspRdata(dU), .rspErr(eU), .targetMask(tgtU));

  irq_target_bank #(.NUM_CPU(1), .NUM_IRQ(64), .LEGACY_REV(1'b1)) u_leg (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqCpu(1'b0),
    .rspValid(vL), .rspRdata(dL), .rspErr(eL), .targetMask(tgtL));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkMasks(input string req);
    logic okM = 1'b1, okL = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (tgtM[i*4 +: 4] !== expM[i]) okM = 1'b0;
      if (tgtL[i] !== expL[i]) okL = 1'b0;
    end
    check(req, "multi masks match", 32'(okM), 32'd1);
    check(req, "legacy masks match", 32'(okL), 32'd1);
    check("R9", "hidden masks all ones", 32'(tgtU == '1), 32'd1);
  endtask

  // One request, full response check on all three builds
  task automatic access(input string req, input logic wr, input logic [11:0] addr,
                        input logic [7:0] data, input logic [1:0] cpu);
    logic inWin;
    int   irq;
    logic [7:0] xdM, xdL;
    logic xeM;
    inWin = (addr >= 12'h800 && addr <= 12'hBFF);
    irq   = int'(addr) - 32'h800;
    xdM = 8'h00; xdL = 8'h00; xeM = 1'b0;
    if (inWin && irq >= 64) xeM = 1'b1;
    else if (inWin) begin
      if (wr) begin
        if (irq < 29) begin expM[irq] = 4'h0; expL[irq] = 1'b0; end
        else if (irq < 32) begin expM[irq] = 4'hF; expL[irq] = 1'b1; end
        else begin expM[irq] = data[3:0]; expL[irq] = data[0]; end
      end else if (irq >= 29 && irq < 32) begin
        xdM = 8'(1) << cpu; xdL = 8'h01;
      end else begin
        xdM = {4'h0, expM[irq]}; xdL = {7'h0, expL[irq]};
      end
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = data; reqCpu = cpu;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2", "multi rspValid", 32'(vM), 32'd1);
    check(req, "multi data", 32'(dM), 32'(xdM));
    check(req, "multi err", 32'(eM), 32'(xeM));
    check("R10", "legacy data", 32'(dL), 32'(xdL));
    check("R10", "legacy err", 32'(eL), 32'(xeM));
    check("R9", "hidden data", 32'(dU), 32'd0);
    check("R9", "hidden err", 32'(eU), 32'd0);
    checkMasks(req);
    @(negedge clk);
    check("R2", "rspValid single cycle", 32'(vM), 32'd0);
    check("R8", "err single cycle", 32'(eM), 32'd0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 64; i++) begin expM[i] = 4'h0; expL[i] = 1'b1; end
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "rspValid in reset", 32'(vM), 32'd0);
    check("R11", "rspErr in reset", 32'(eM), 32'd0);
    check("R11", "rspRdata in reset", 32'(dM), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "multi masks zero", 32'(tgtM == '0), 32'd1);
    check("R10", "legacy masks one", 32'(tgtL == '1), 32'd1);
    check("R9", "hidden masks one", 32'(tgtU == '1), 32'd1);
  endtask

  task automatic t_shared;
    access("R4", 1'b1, 12'h828, 8'hFF, 2'd1);
    access("R3", 1'b0, 12'h828, 8'h00, 2'd0);
    access("R4", 1'b1, 12'h83F, 8'hA5, 2'd2);
    access("R3", 1'b0, 12'h83F, 8'h00, 2'd3);
    access("R4", 1'b1, 12'h821, 8'h3C, 2'd0);
    access("R3", 1'b0, 12'h821, 8'h00, 2'd1);
  endtask

  task automatic t_lowPrivate;
    access("R5", 1'b1, 12'h805, 8'hFF, 2'd0);
    access("R5", 1'b0, 12'h805, 8'h00, 2'd0);
    access("R5", 1'b1, 12'h81C, 8'h0F, 2'd3);
  endtask

  task automatic t_selfLines;
    access("R6", 1'b1, 12'h81E, 8'h00, 2'd0);
    access("R7", 1'b0, 12'h81D, 8'h00, 2'd2);
    access("R7", 1'b0, 12'h81E, 8'h00, 2'd3);
    access("R7", 1'b0, 12'h81F, 8'h00, 2'd0);
    access("R6", 1'b1, 12'h81F, 8'h01, 2'd1);
  endtask

  task automatic t_invalid;
    access("R8", 1'b0, 12'h840, 8'h00, 2'd0);
    access("R8", 1'b1, 12'h850, 8'hFF, 2'd1);
    access("R8", 1'b1, 12'hBFF, 8'hFF, 2'd2);
  endtask

  task automatic t_window;
    access("R1", 1'b1, 12'h7FF, 8'hFF, 2'd0);
    access("R1", 1'b1, 12'hC28, 8'h00, 2'd0);
    access("R1", 1'b0, 12'h028, 8'h00, 2'd1);
    access("R3", 1'b0, 12'h828, 8'h00, 2'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_shared();
    t_lowPrivate();
    t_selfLines();
    t_invalid();
    t_window();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule